// File: doc/BRIEF.md
# Stream Command Dispatcher with Port Scoreboard

This block sits between a control processor and three stream engines. The engines serve main memory, the scratchpad, and output-to-input recurrence. The processor sends a command stream that mixes stream commands, configure commands and barrier commands. Commands wait in an in-order queue, and only the head command is ever considered for issue.

Each stream command names a mask of input vector ports and a mask of output vector ports. A scoreboard keeps one busy bit per port. The head stream command is offered to its engine only when none of its ports is busy. The busy bits are set when the engine accepts the command. They are cleared when that engine reports completion with the masks it frees.

A configure command waits until every port is idle and then announces the new dataflow graph identifier. A barrier command waits either for all ports to go idle or for the scratchpad engine to have no live stream. While a barrier waits, every command queued behind it also waits.

Top module: `strm_dispatch`

## Requirements
- R1: The queue holds up to DEPTH (default 16) commands. cmd_ready is low whenever the queue is full. Commands leave the queue strictly in arrival order.
- R2: A stream command is routed by cmd_kind. Code 0 goes to the memory engine (eng_valid bit 0), code 1 to the scratchpad engine (bit 1) and code 2 to the recurrence engine (bit 2). At most one eng_valid bit is high, and eng_src_mask and eng_dst_mask carry the head command's masks.
- R3: A head stream command is not offered while any port in its input mask or output mask is busy. Its ports become busy in the cycle after its engine accepts it.
- R4: When done_valid bit e is high, the input and output ports given in slice e of done_src_mask and done_dst_mask become free. A release and a new issue in the same cycle both take effect, and the release counts before the port check.
- R5: If the target engine's eng_ready is low, the head command is held with stable valid and masks, and the commands behind it wait.
- R6: No port is granted to a stream while another live stream holds it.
- R7: A barrier-all command (code 4) leaves the queue only when every input and output busy bit is clear. Until then no later command issues.
- R8: A barrier-scratchpad command (code 5) leaves the queue only when no scratchpad-engine stream is live. Live memory or recurrence streams do not hold it.
- R9: A configure command (code 3) issues only when every port is idle. It then raises cfg_valid for one cycle with cfg_id equal to its cmd_cfg_id, and no stream is offered in that cycle.
- R10: After reset the queue is empty, all ports are free, cmd_ready is high, and eng_valid and cfg_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered by the processor |
| cmd_ready | output | 1 | Queue can accept a command |
| cmd_kind | input | 3 | 0 mem, 1 scratchpad, 2 recurrence, 3 configure, 4 barrier-all, 5 barrier-scratchpad |
| cmd_src_mask | input | NPORT | Input vector ports named by a stream |
| cmd_dst_mask | input | NPORT | Output vector ports named by a stream |
| cmd_cfg_id | input | CFG_W | Graph identifier for a configure command |
| eng_valid | output | 3 | Command offered to engine (bit per engine) |
| eng_ready | input | 3 | Engine can accept a command |
| eng_src_mask | output | NPORT | Input port mask of the offered stream |
| eng_dst_mask | output | NPORT | Output port mask of the offered stream |
| done_valid | input | 3 | Completion report per engine |
| done_src_mask | input | 3*NPORT | Freed input ports, NPORT bits per engine |
| done_dst_mask | input | 3*NPORT | Freed output ports, NPORT bits per engine |
| cfg_valid | output | 1 | One-cycle configure pulse |
| cfg_id | output | CFG_W | Graph identifier, meaningful with cfg_valid |

## Verification
Two things can happen in the same cycle: a completion frees ports, and the blocked head command claims those same ports. The bench first parks a stream on a port that a live stream holds. It then raises that engine's completion and probes within that cycle, expecting the engine offer to be already high. A barrier or a configure command is judged the same way: it must resolve in the very cycle the last release arrives.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;
   localparam int NUM_ENG = 3;
   localparam int KIND_W  = 3;

   localparam logic [KIND_W-1:0] KIND_MEM      = 3'd0;
   localparam logic [KIND_W-1:0] KIND_SPAD     = 3'd1;
   localparam logic [KIND_W-1:0] KIND_RECUR    = 3'd2;
   localparam logic [KIND_W-1:0] KIND_CFG      = 3'd3;
   localparam logic [KIND_W-1:0] KIND_BAR_ALL  = 3'd4;
   localparam logic [KIND_W-1:0] KIND_BAR_SPAD = 3'd5;

   localparam int ENG_SPAD = 1;
endpackage

// File: rtl/sdisp_fifo.sv
module sdisp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr, rd_nx, wr_nx;
   logic [CW-1:0] level;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (POW2) begin : g_wrap_nat
      assign rd_nx = rd_ptr + AW'(1);
      assign wr_nx = wr_ptr + AW'(1);
   end else begin : g_wrap_cmp
      assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nx;
         if (do_pop)  rd_ptr <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end

   assign dout  = mem[rd_ptr];
   assign empty = (level == '0);
   assign full  = (level == CW'(DEPTH));
endmodule

// File: rtl/sdisp_scoreboard.sv
module sdisp_scoreboard #(
   parameter int NPORT    = 8,
   parameter int NENG     = 3,
   parameter int CNT_W    = 4,
   parameter int SPAD_IDX = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NPORT-1:0]      set_src,
   input  logic [NPORT-1:0]      set_dst,
   input  logic                  spad_issue,
   input  logic [NENG-1:0]       done_valid,
   input  logic [NENG*NPORT-1:0] done_src_mask,
   input  logic [NENG*NPORT-1:0] done_dst_mask,
   output logic [NPORT-1:0]      in_busy,
   output logic [NPORT-1:0]      out_busy,
   output logic [NPORT-1:0]      in_eff,
   output logic [NPORT-1:0]      out_eff,
   output logic                  spad_idle
);
   logic [NPORT-1:0] rel_in_acc  [NENG+1];
   logic [NPORT-1:0] rel_out_acc [NENG+1];
   logic [CNT_W-1:0] spad_live;
   logic             spad_dec;

   assign rel_in_acc[0]  = '0;
   assign rel_out_acc[0] = '0;

   for (genvar e = 0; e < NENG; e++) begin : g_rel
      assign rel_in_acc[e+1]  = rel_in_acc[e] |
                                (done_valid[e] ? done_src_mask[e*NPORT +: NPORT] : '0);
      assign rel_out_acc[e+1] = rel_out_acc[e] |
                                (done_valid[e] ? done_dst_mask[e*NPORT +: NPORT] : '0);
   end

   // release counts before the port check of the same cycle
   assign in_eff  = in_busy  & ~rel_in_acc[NENG];
   assign out_eff = out_busy & ~rel_out_acc[NENG];

   assign spad_dec  = done_valid[SPAD_IDX] && (spad_live != '0);
   assign spad_idle = (spad_live == '0) || ((spad_live == CNT_W'(1)) && spad_dec);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_busy   <= '0;
         out_busy  <= '0;
         spad_live <= '0;
      end else begin
         in_busy   <= in_eff  | set_src;
         out_busy  <= out_eff | set_dst;
         spad_live <= spad_live + CNT_W'(spad_issue) - CNT_W'(spad_dec);
      end
   end
endmodule

// File: rtl/sdisp_issue.sv
module sdisp_issue
   import sdisp_pkg::*;
#(
   parameter int NPORT = 8
) (
   input  logic              head_valid,
   input  logic [KIND_W-1:0] head_kind,
   input  logic [NPORT-1:0]  head_src,
   input  logic [NPORT-1:0]  head_dst,
   input  logic [NPORT-1:0]  in_eff,
   input  logic [NPORT-1:0]  out_eff,
   input  logic              spad_idle,
   input  logic [NUM_ENG-1:0] eng_ready,
   output logic [NUM_ENG-1:0] eng_valid,
   output logic              pop,
   output logic              cfg_go,
   output logic [NPORT-1:0]  set_src,
   output logic [NPORT-1:0]  set_dst,
   output logic              spad_issue
);
   logic is_stream, ports_ok, all_idle, fire, bar_go, bad_kind;

   always_comb begin
      is_stream = head_valid && (head_kind <= KIND_RECUR);
      ports_ok  = ((head_src & in_eff) == '0) && ((head_dst & out_eff) == '0);
      all_idle  = (in_eff == '0) && (out_eff == '0);

      eng_valid = '0;
      if (is_stream && ports_ok) eng_valid = NUM_ENG'(1) << head_kind;

      fire       = (eng_valid & eng_ready) != '0;
      spad_issue = fire && (head_kind == KIND_SPAD);
      cfg_go     = head_valid && (head_kind == KIND_CFG) && all_idle;
      bar_go     = head_valid &&
                   (((head_kind == KIND_BAR_ALL) && all_idle) ||
                    ((head_kind == KIND_BAR_SPAD) && spad_idle));
      bad_kind   = head_valid && (head_kind > KIND_BAR_SPAD);
      pop        = fire || cfg_go || bar_go || bad_kind;

      set_src = fire ? head_src : '0;
      set_dst = fire ? head_dst : '0;
   end
endmodule

// File: rtl/strm_dispatch.sv
module strm_dispatch
   import sdisp_pkg::*;
#(
   parameter int NPORT = 8,
   parameter int DEPTH = 16,
   parameter int CFG_W = 4,
   parameter int CNT_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   output logic                     cmd_ready,
   input  logic [2:0]               cmd_kind,
   input  logic [NPORT-1:0]         cmd_src_mask,
   input  logic [NPORT-1:0]         cmd_dst_mask,
   input  logic [CFG_W-1:0]         cmd_cfg_id,
   output logic [2:0]               eng_valid,
   input  logic [2:0]               eng_ready,
   output logic [NPORT-1:0]         eng_src_mask,
   output logic [NPORT-1:0]         eng_dst_mask,
   input  logic [2:0]               done_valid,
   input  logic [3*NPORT-1:0]       done_src_mask,
   input  logic [3*NPORT-1:0]       done_dst_mask,
   output logic                     cfg_valid,
   output logic [CFG_W-1:0]         cfg_id
);
   localparam int W = KIND_W + 2 * NPORT + CFG_W;

   if (NPORT < 1)  begin : g_bad_nport $error("NPORT must be at least 1"); end
   if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (CFG_W < 1)  begin : g_bad_cfgw  $error("CFG_W must be at least 1"); end
   if (CNT_W < 1)  begin : g_bad_cntw  $error("CNT_W must be at least 1"); end
   if (NUM_ENG != 3) begin : g_bad_eng $error("engine count is fixed at 3"); end

   logic [W-1:0]      head_word;
   logic              q_empty, q_full, q_pop;
   logic [KIND_W-1:0] head_kind;
   logic [NPORT-1:0]  head_src, head_dst;
   logic [CFG_W-1:0]  head_cfg;
   logic [NPORT-1:0]  in_busy, out_busy, in_eff, out_eff, set_src, set_dst;
   logic              spad_idle, spad_issue, cfg_go;

   assign cmd_ready = !q_full;

   sdisp_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (cmd_valid && cmd_ready),
      .din   ({cmd_kind, cmd_src_mask, cmd_dst_mask, cmd_cfg_id}),
      .pop   (q_pop),
      .dout  (head_word),
      .empty (q_empty),
      .full  (q_full)
   );

   assign {head_kind, head_src, head_dst, head_cfg} = head_word;

   sdisp_scoreboard #(.NPORT(NPORT), .NENG(NUM_ENG), .CNT_W(CNT_W), .SPAD_IDX(ENG_SPAD)) u_sb (
      .clk           (clk),
      .rst_n         (rst_n),
      .set_src       (set_src),
      .set_dst       (set_dst),
      .spad_issue    (spad_issue),
      .done_valid    (done_valid),
      .done_src_mask (done_src_mask),
      .done_dst_mask (done_dst_mask),
      .in_busy       (in_busy),
      .out_busy      (out_busy),
      .in_eff        (in_eff),
      .out_eff       (out_eff),
      .spad_idle     (spad_idle)
   );

   sdisp_issue #(.NPORT(NPORT)) u_issue (
      .head_valid (!q_empty),
      .head_kind  (head_kind),
      .head_src   (head_src),
      .head_dst   (head_dst),
      .in_eff     (in_eff),
      .out_eff    (out_eff),
      .spad_idle  (spad_idle),
      .eng_ready  (eng_ready),
      .eng_valid  (eng_valid),
      .pop        (q_pop),
      .cfg_go     (cfg_go),
      .set_src    (set_src),
      .set_dst    (set_dst),
      .spad_issue (spad_issue)
   );

   assign eng_src_mask = head_src;
   assign eng_dst_mask = head_dst;
   assign cfg_valid    = cfg_go;
   assign cfg_id       = head_cfg;
endmodule

// File: rtl/sdisp_chk.sv
module sdisp_chk #(
   parameter int NPORT = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         eng_valid,
   input logic [2:0]         eng_ready,
   input logic [NPORT-1:0]   eng_src_mask,
   input logic [NPORT-1:0]   eng_dst_mask,
   input logic [2:0]         done_valid,
   input logic [3*NPORT-1:0] done_src_mask,
   input logic [3*NPORT-1:0] done_dst_mask,
   input logic               cfg_valid,
   input logic [NPORT-1:0]   in_busy,
   input logic [NPORT-1:0]   out_busy
);
   logic [NPORT-1:0] rel_in, rel_out;
   logic             fire;

   always_comb begin
      rel_in  = '0;
      rel_out = '0;
      for (int e = 0; e < 3; e++) begin
         if (done_valid[e]) begin
            rel_in  = rel_in  | done_src_mask[e*NPORT +: NPORT];
            rel_out = rel_out | done_dst_mask[e*NPORT +: NPORT];
         end
      end
      fire = (eng_valid & eng_ready) != 3'b000;
   end

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eng_valid));

   p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (((eng_src_mask & in_busy & ~rel_in) == '0) &&
                ((eng_dst_mask & out_busy & ~rel_out) == '0)));

   p_set_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (((in_busy & $past(eng_src_mask)) == $past(eng_src_mask)) &&
                ((out_busy & $past(eng_dst_mask)) == $past(eng_dst_mask))));

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_valid != 3'b000) && !fire) |=>
         (((in_busy & $past(rel_in)) == '0) && ((out_busy & $past(rel_out)) == '0)));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((eng_valid != 3'b000) && !fire) |=>
         ($stable(eng_valid) && $stable(eng_src_mask) && $stable(eng_dst_mask)));

   p_cfg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (((in_busy & ~rel_in) == '0) && ((out_busy & ~rel_out) == '0)));

   p_cfg_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (eng_valid == 3'b000));
endmodule

bind strm_dispatch sdisp_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/sim_strm_dispatch.sv
module sim_strm_dispatch;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_kind = '0;
   logic [NP-1:0] cmd_src_mask = '0, cmd_dst_mask = '0;
   logic [3:0]    cmd_cfg_id = '0;
   logic [2:0]    eng_valid;
   logic [2:0]    eng_ready = 3'b111;
   logic [NP-1:0] eng_src_mask, eng_dst_mask;
   logic [2:0]    done_valid = '0;
   logic [3*NP-1:0] done_src_mask = '0, done_dst_mask = '0;
   logic          cfg_valid;
   logic [3:0]    cfg_id;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [17:0] exp_q [$];

   always #4 clk = ~clk;

   strm_dispatch u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_cmd(input logic [2:0] k, input logic [7:0] s, input logic [7:0] d,
                           input logic [3:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_kind = k; cmd_src_mask = s; cmd_dst_mask = d; cmd_cfg_id = c;
      #1;
      while (!cmd_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic expect_issue(input int e, input logic [7:0] s, input logic [7:0] d);
      exp_q.push_back({e[1:0], s, d});
   endtask

   task automatic stream(input int e, input logic [7:0] s, input logic [7:0] d);
      expect_issue(e, s, d);
      push_cmd(3'(e), s, d, 4'h0);
   endtask

   task automatic done_on(input int e, input logic [7:0] s, input logic [7:0] d);
      done_valid = 3'b001 << e;
      done_src_mask = '0; done_dst_mask = '0;
      done_src_mask[e*NP +: NP] = s;
      done_dst_mask[e*NP +: NP] = d;
   endtask

   task automatic done_off();
      done_valid = '0; done_src_mask = '0; done_dst_mask = '0;
   endtask

   task automatic release_ports(input int e, input logic [7:0] s, input logic [7:0] d);
      @(negedge clk); done_on(e, s, d);
      @(negedge clk); done_off();
   endtask

   task automatic probe();
      @(negedge clk); #3;
   endtask

   // monitor: every engine handshake is compared with the next expected item
   always begin
      @(negedge clk); #3;
      if (rst_n) begin
         for (int e = 0; e < 3; e++) begin
            if (eng_valid[e] && eng_ready[e]) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2 unexpected issue", {e[1:0], eng_src_mask, eng_dst_mask}, 0);
               end else begin
                  logic [17:0] want;
                  want = exp_q.pop_front();
                  chk({e[1:0], eng_src_mask, eng_dst_mask} == want, "R2 R1 issue order/route",
                      {e[1:0], eng_src_mask, eng_dst_mask}, want);
               end
            end
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #3;
      chk(cmd_ready == 1'b1, "R10 cmd_ready", cmd_ready, 1);
      chk(eng_valid == 3'b000, "R10 eng_valid", eng_valid, 0);
      chk(cfg_valid == 1'b0, "R10 cfg_valid", cfg_valid, 0);

      // routing to the three engines
      stream(0, 8'h01, 8'h01);
      stream(1, 8'h02, 8'h02);
      stream(2, 8'h04, 8'h04);

      // blocked on busy input port 0, freed by a same-cycle completion
      stream(0, 8'h01, 8'h10);
      probe();
      chk(eng_valid == 3'b000, "R3 blocked on busy port", eng_valid, 0);
      chk(exp_q.size() == 1, "R6 port not granted twice", exp_q.size(), 1);
      @(negedge clk); done_on(0, 8'h01, 8'h01); #3;
      chk(eng_valid == 3'b001, "R4 release and issue same cycle", eng_valid, 3'b001);
      @(negedge clk); done_off();

      // barrier-scratchpad: waits for the scratchpad stream only
      push_cmd(3'd5, 8'h00, 8'h00, 4'h0);
      stream(2, 8'h08, 8'h08);
      probe();
      chk(eng_valid == 3'b000, "R8 barrier holds later stream", eng_valid, 0);
      @(negedge clk); done_on(1, 8'h02, 8'h02);
      @(negedge clk); done_off(); #3;
      chk(eng_valid == 3'b100, "R8 barrier resolved by scratchpad done", eng_valid, 3'b100);

      // barrier-all: waits for every port
      push_cmd(3'd4, 8'h00, 8'h00, 4'h0);
      stream(0, 8'h20, 8'h20);
      release_ports(0, 8'h01, 8'h10);
      release_ports(2, 8'h04, 8'h04);
      #3;
      chk(eng_valid == 3'b000, "R7 barrier holds while ports busy", eng_valid, 0);
      @(negedge clk); done_on(2, 8'h08, 8'h08);
      @(negedge clk); done_off(); #3;
      chk(eng_valid == 3'b001, "R7 stream issues after barrier", eng_valid, 3'b001);

      // configure waits for idle, pulses for one cycle
      push_cmd(3'd3, 8'h00, 8'h00, 4'h5);
      probe();
      chk(cfg_valid == 1'b0, "R9 config held while busy", cfg_valid, 0);
      @(negedge clk); done_on(0, 8'h20, 8'h20); #3;
      chk(cfg_valid == 1'b1, "R9 config pulse", cfg_valid, 1);
      chk(cfg_id == 4'h5, "R9 config id", cfg_id, 5);
      @(negedge clk); done_off(); #3;
      chk(cfg_valid == 1'b0, "R9 pulse is one cycle", cfg_valid, 0);

      // engine not ready: head and followers wait
      @(negedge clk); eng_ready = 3'b101;
      stream(1, 8'h40, 8'h40);
      stream(0, 8'h80, 8'h80);
      probe();
      chk(eng_valid == 3'b010, "R5 head held for busy engine", eng_valid, 3'b010);
      chk(exp_q.size() == 2, "R5 nothing issued past head", exp_q.size(), 2);
      @(negedge clk); eng_ready = 3'b111;
      repeat (3) probe();
      chk(exp_q.size() == 0, "R5 both issued once ready", exp_q.size(), 0);
      release_ports(1, 8'h40, 8'h40);
      release_ports(0, 8'h80, 8'h80);

      // fill the queue
      @(negedge clk); eng_ready = 3'b000;
      for (int i = 0; i < 16; i++) stream(0, 8'h00, 8'h00);
      probe();
      chk(cmd_ready == 1'b0, "R1 backpressure when full", cmd_ready, 0);
      chk(eng_valid == 3'b001, "R1 head offered while engine stalls", eng_valid, 3'b001);
      @(negedge clk); eng_ready = 3'b111;
      repeat (20) probe();
      chk(exp_q.size() == 0, "R1 queue drained in order", exp_q.size(), 0);
      chk(cmd_ready == 1'b1, "R1 ready after drain", cmd_ready, 1);

      summary();
   end
endmodule